// File: doc/BRIEF.md
# Operate Instruction Execution Unit

This unit executes the three register-to-register arithmetic and logic operations of a small 16-bit load/store machine: addition, bitwise AND and bitwise inversion. Each cycle the sequencer may issue one 16-bit instruction word. The unit decodes the two source register indices, which go to a register file with two read ports. It takes the two operand words that come back and computes the result. One cycle after issue it presents the result, the destination index and a write strobe for the register file's single write port.

The second operand is either the second source register or a 5-bit immediate from the instruction, sign-extended. The unit also holds the machine's negative/zero/positive flag register. That register is reloaded from every value the unit writes, and exactly one of its three flags is set at all times.

Top module: `operate_unit`

## Requirements
- R1: Opcode 0001 in instruction bits [15:12] writes the sum of the first operand and the second operand, wrapped modulo 2^16.
- R2: Opcode 0101 writes the bitwise AND of the first operand and the second operand.
- R3: Opcode 1001 writes the bitwise inversion of `src_a`. Instruction bits [5:0] and `src_b` have no effect on the result.
- R4: For ADD and AND, instruction bit 5 selects the second operand. When bit 5 is 0 it is `src_b`. When bit 5 is 1 it is bits [4:0] sign-extended to 16 bits, and `src_b` is ignored.
- R5: `rd_idx_a` always equals instruction bits [8:6] and `rd_idx_b` always equals bits [2:0], combinationally. A write goes to the register index held in bits [11:9] of the issued instruction.
- R6: A legal instruction issued at a rising edge raises `wr_en` for exactly the following cycle. `wr_data` and `wr_idx` are valid in that same cycle. `wr_en` is 0 in any cycle that does not follow an issue.
- R7: Each write loads the flags from the written value. `flag_n` is set when bit 15 is 1, `flag_z` when the value is zero, and `flag_p` otherwise. Exactly one flag is set at all times.
- R8: While reset is held, `wr_en`, `wr_idx` and `wr_data` are 0 and the flags read Z=1, N=0, P=0.
- R9: An issued word whose opcode is not one of the three above produces no write and leaves the flags unchanged.
- R10: Cycles without an issue leave the flags and the last `wr_data` and `wr_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| src_a | input | WIDTH | Value read from register `rd_idx_a` |
| src_b | input | WIDTH | Value read from register `rd_idx_b` |
| rd_idx_a | output | 3 | First source register index |
| rd_idx_b | output | 3 | Second source register index |
| wr_en | output | 1 | Register file write strobe |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | WIDTH | Value to write |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
The bench targets several corner cases:
- Additions that wrap through zero, and additions that cross into the sign bit. A unit that mishandled these would set P where N or Z belongs.
- Immediates with bit 4 set. A missing sign extension would turn -1 into +31 and corrupt both sum and flags.
- An immediate-mode instruction with a garbage `src_b`. This catches a selector that reads the wrong source.
- NOT words whose low six bits are zero instead of all ones. These expose a decoder that wrongly treats those bits as an operand select.
- Illegal opcodes and idle cycles issued right after a write. A unit that wrote or reloaded its flags there would show a spurious strobe or a changed flag.

// File: rtl/operate_unit.sv
module operate_unit #(
  parameter int WIDTH = 16,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [15:0]      instr,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [2:0]       rd_idx_a,
  output logic [2:0]       rd_idx_b,
  output logic             wr_en,
  output logic [2:0]       wr_idx,
  output logic [WIDTH-1:0] wr_data,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_p
);

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam int EXT_W = WIDTH - IMM_W;

  logic [3:0]       opc;
  logic [WIDTH-1:0] imm_ext;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] alu_out;
  logic             legal;
  logic             do_write;

  assign opc      = instr[15:12];
  assign rd_idx_a = instr[8:6];
  assign rd_idx_b = instr[2:0];
  assign imm_ext  = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign opnd_b   = instr[5] ? imm_ext : src_b;

  always_comb begin
    legal   = 1'b1;
    alu_out = '0;
    case (opc)
      OPC_ADD: alu_out = src_a + opnd_b;
      OPC_AND: alu_out = src_a & opnd_b;
      OPC_NOT: alu_out = ~src_a;
      default: legal = 1'b0;
    endcase
  end

  assign do_write = issue & legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b1;
      flag_p  <= 1'b0;
    end else begin
      wr_en <= do_write;
      if (do_write) begin
        wr_idx  <= instr[11:9];
        wr_data <= alu_out;
        flag_n  <= alu_out[WIDTH-1];
        flag_z  <= (alu_out == '0);
        flag_p  <= ~alu_out[WIDTH-1] & (alu_out != '0);
      end
    end
  end

  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1);

  assert_flags_track_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flag_z == (wr_data == '0)) && (flag_n == wr_data[WIDTH-1]));

  assert_write_needs_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(issue));

  assert_not_inverts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[15:12] == 4'b1001) |=> (wr_en && wr_data == ~$past(src_a)));

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[15:12] != 4'b0001 && instr[15:12] != 4'b0101
           && instr[15:12] != 4'b1001) |=> !wr_en);

  assert_idle_holds_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $stable({flag_n, flag_z, flag_p}));

endmodule

// File: tb/operate_unit_test.sv
module operate_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] src_a = '0;
  logic [15:0] src_b = '0;
  logic [2:0]  rd_idx_a, rd_idx_b, wr_idx;
  logic        wr_en, flag_n, flag_z, flag_p;
  logic [15:0] wr_data;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  logic        exp_wr = 1'b0;
  logic [15:0] exp_res = '0;
  logic [2:0]  exp_dst = '0;
  logic [2:0]  exp_flags = 3'b010;

  always #(PERIOD/2) clk = ~clk;

  operate_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .src_a(src_a), .src_b(src_b), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int opc, input int dst, input int s1,
                                     input int low6);
    return 16'((opc << 12) | (dst << 9) | (s1 << 6) | low6);
  endfunction

  task automatic apply(input logic iss, input logic [15:0] ins,
                       input logic [15:0] a, input logic [15:0] b, input string tag);
    int opb;
    int imm;
    logic [15:0] r;
    logic ok;
    string ftag;
    @(negedge clk);
    issue = iss; instr = ins; src_a = a; src_b = b;
    #1;
    chk("R5", "rd_idx_a", int'(rd_idx_a), int'(ins[8:6]));
    chk("R5", "rd_idx_b", int'(rd_idx_b), int'(ins[2:0]));
    @(posedge clk);
    if (ins[5]) begin
      imm = int'(ins[4:0]);
      if (imm >= 16) imm = imm - 32;
      opb = imm;
    end else opb = int'(b);
    ok = 1'b1;
    r = '0;
    case (int'(ins[15:12]))
      1: r = 16'((int'(a) + opb) % 65536);
      5: r = a & 16'(opb);
      9: r = ~a;
      default: ok = 1'b0;
    endcase
    if (iss && ok) begin
      exp_wr = 1'b1; exp_res = r; exp_dst = ins[11:9];
      if (int'(r) >= 32768) exp_flags = 3'b100;
      else if (r == 0) exp_flags = 3'b010;
      else exp_flags = 3'b001;
    end else exp_wr = 1'b0;
    #1;
    ftag = (tag == "R9" || tag == "R10") ? tag : "R7";
    chk((tag == "R9" || tag == "R10") ? tag : "R6", "wr_en", int'(wr_en), int'(exp_wr));
    chk(tag, "wr_data", int'(wr_data), int'(exp_res));
    chk((tag == "R10") ? tag : "R5", "wr_idx", int'(wr_idx), int'(exp_dst));
    chk(ftag, "flags", int'({flag_n, flag_z, flag_p}), int'(exp_flags));
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    string t;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "wr_en", int'(wr_en), 0);
    chk("R8", "wr_data", int'(wr_data), 0);
    chk("R8", "wr_idx", int'(wr_idx), 0);
    chk("R8", "flags", int'({flag_n, flag_z, flag_p}), 3'b010);
    @(negedge clk);
    rst_n = 1'b1;

    apply(1, mk(1, 3, 2, 6'b000001), 16'h1234, 16'h0F0F, "R1");
    apply(1, mk(1, 6, 3, 6'b000010), 16'hFFF6, 16'h0008, "R1");
    apply(1, mk(1, 1, 1, 6'b000001), 16'hFFFF, 16'h0001, "R1");
    apply(1, mk(1, 2, 0, 6'b000000), 16'h7FFF, 16'h0001, "R1");
    apply(1, mk(1, 4, 5, 6'b111111), 16'h0005, 16'hABCD, "R4");
    apply(1, mk(1, 4, 5, 6'b101111), 16'h0005, 16'h8000, "R4");
    apply(1, mk(1, 7, 7, 6'b110000), 16'h0010, 16'h1111, "R4");
    apply(1, mk(5, 5, 2, 6'b000011), 16'hF0F0, 16'h3C3C, "R2");
    apply(1, mk(5, 1, 3, 6'b110101), 16'hFFF6, 16'h0000, "R4");
    apply(1, mk(5, 0, 0, 6'b100000), 16'hBEEF, 16'hFFFF, "R2");
    apply(1, mk(9, 5, 3, 6'b111111), 16'hFFF6, 16'h1234, "R3");
    apply(1, mk(9, 2, 2, 6'b000000), 16'h0000, 16'h5555, "R3");
    apply(1, mk(9, 3, 4, 6'b010101), 16'h00FF, 16'hFFFF, "R3");
    apply(1, mk(2, 6, 1, 6'b000000), 16'h0000, 16'h0000, "R9");
    apply(1, mk(0, 1, 1, 6'b100001), 16'h0001, 16'h0000, "R9");
    apply(1, mk(15, 7, 1, 6'b111111), 16'h8000, 16'h8000, "R9");
    apply(0, mk(1, 2, 1, 6'b000001), 16'h0000, 16'h0000, "R10");
    apply(0, mk(9, 4, 1, 6'b111111), 16'hFFFF, 16'h0000, "R10");

    for (int i = 0; i < 400; i++) begin
      int sel;
      int opc;
      sel = int'($urandom_range(0, 4));
      opc = (sel == 0) ? 1 : (sel == 1) ? 5 : (sel == 2) ? 9 : (sel == 3) ? 1 : 12;
      t = (opc == 1) ? "R1" : (opc == 5) ? "R2" : (opc == 9) ? "R3" : "R9";
      apply(($urandom_range(0, 9) != 0), mk(opc, int'($urandom_range(0, 7)),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 63))),
            16'($urandom), 16'($urandom), t);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule